// File: doc/BRIEF.md
# Per-Block Write Protection Controller

This block keeps the write-protection state of a word-wide flash array that is split into fifteen erase blocks: eight small parameter blocks of 4K words and seven large main blocks of 32K words, 256K words in all. A strap input places the small blocks either at the bottom of the address space or at the top. Any word address given to the block is decoded into the index of the erase block that contains it. Blocks are numbered 0 to 14 in rising address order.

Each block holds two state bits: a lock bit and a lock-down bit. Commands that carry an address set or clear these bits for the block that contains the address. The write-protect pin decides whether a lock-down bit can be overridden. A program or erase request is allowed only when three conditions hold: the addressed block is unlocked, it is not held by lock-down, and the programming-voltage-low indicator is clear. A refused request sets a sticky error flag. A status port reports the two state bits of any block on request. The array, the command parser and the program/erase algorithms sit around this block.

Top module: `blk_protect_ctrl`

## Requirements
- R1: While reset is asserted and right after it, every block has its lock bit set and its lock-down bit clear, and the error flag is low.
- R2: With `boot_top` low, addresses 0x00000 to 0x07FFF form eight 4K-word blocks with indices 0 to 7 (index = addr[14:12]). Each further 32K-word span is one block, with index 7 + addr[17:15].
- R3: With `boot_top` high, addresses 0x38000 to 0x3FFFF form eight 4K-word blocks with indices 7 to 14 (index = 7 + addr[14:12]). Below that span, each 32K-word span is one block, with index addr[17:15].
- R4: `cmd_op` is encoded as follows: 2'b01 is lock (set lock), 2'b10 is unlock (clear lock), 2'b11 is lock-down (set both bits) and 2'b00 does nothing. A command with `cmd_valid` high acts only on the block that contains `cmd_addr`. Its effect is visible from the next clock cycle.
- R5: An unlock sent to a block whose lock-down bit is set is ignored while `wp` is low, and accepted while `wp` is high. Once set, a lock-down bit is cleared only by reset.
- R6: `prog_ok` is a combinational output. It is high exactly when `req_valid` is high, the addressed block's lock bit is clear, the block is not held by lock-down, and `vpp_low` is low. A block is held by lock-down when its lock-down bit is set while `wp` is low.
- R7: While `vpp_low` is high, `prog_ok` is low for every address and every lock state.
- R8: A request with `req_valid` high and `prog_ok` low sets `prot_err` from the next cycle. The flag then stays high until a cycle with `err_clr` high and no refused request. When a refused request and `err_clr` arrive in the same cycle, the flag is set.
- R9: `qry_lock` and `qry_down` show, combinationally, the lock bit and the lock-down bit of the block that contains `qry_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_top | input | 1 | Strap: 1 puts the parameter blocks at the top |
| wp | input | 1 | Write-protect pin; low enforces lock-down |
| vpp_low | input | 1 | Programming voltage below lockout level |
| cmd_valid | input | 1 | Lock command strobe |
| cmd_op | input | 2 | Lock command code |
| cmd_addr | input | 18 | Word address that selects the command's block |
| req_valid | input | 1 | Program/erase request strobe |
| req_addr | input | 18 | Word address of the request |
| prog_ok | output | 1 | Request allowed |
| err_clr | input | 1 | Clears the protection-error flag |
| prot_err | output | 1 | Sticky protection-error flag |
| qry_addr | input | 18 | Word address of the status query |
| qry_lock | output | 1 | Lock bit of the queried block |
| qry_down | output | 1 | Lock-down bit of the queried block |

## Verification
The decode is probed at the first and last word of neighbouring blocks under both strap settings. This shows an off-by-one boundary, or a swapped top and bottom map, as a command that lands in the wrong block. A sweep unlocks every other block and then queries and requests each one, which catches commands that leak into neighbouring blocks. Lock-down is tried with `wp` low, then high, then low again, and afterwards through a reset, which separates unlock acceptance from lock-down retention. Requests with `vpp_low` high on an unlocked block, and an error clear given in the same cycle as a refusal, show how the voltage lockout and the clear rank against the other conditions.

// File: rtl/bp_pkg.sv
// Shared types for the block write-protection controller.
// Assumes the command code width is fixed at two bits.
package bp_pkg;
    typedef enum logic [1:0] {
        OP_NONE   = 2'b00,
        OP_LOCK   = 2'b01,
        OP_UNLOCK = 2'b10,
        OP_DOWN   = 2'b11
    } bp_op_e;
endpackage

// File: rtl/bp_addr_dec.sv
// Maps a word address to an erase-block index, blocks numbered by rising address.
// Assumes the small-block region fills exactly one large-block span.
module bp_addr_dec #(
    parameter int ADDR_W   = 18,
    parameter int MAIN_AW  = 15,
    parameter int PARAM_AW = 12,
    parameter int IDX_W    = 4
) (
    input  logic              boot_top,
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);
    localparam int HI_W  = ADDR_W - MAIN_AW;
    localparam int SUB_W = MAIN_AW - PARAM_AW;
    localparam int NMAIN = (2 ** HI_W) - 1;
    localparam int NPAR  = 2 ** SUB_W;

    logic [HI_W-1:0]  hi;
    logic [SUB_W-1:0] sub;

    assign hi  = addr[ADDR_W-1:MAIN_AW];
    assign sub = addr[MAIN_AW-1:PARAM_AW];

    // Choose the index from the coarse or fine address field per strap.
    always_comb begin
        if (boot_top) begin
            if (&hi) idx = IDX_W'(NMAIN) + IDX_W'(sub);
            else     idx = IDX_W'(hi);
        end else begin
            if (hi == '0) idx = IDX_W'(sub);
            else          idx = IDX_W'(NPAR - 1) + IDX_W'(hi);
        end
    end
endmodule

// File: rtl/bp_lock_cell.sv
// Lock and lock-down state of one erase block.
// Assumes sel is high only when a valid command addresses this block.
module bp_lock_cell
    import bp_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sel,
    input  bp_op_e op,
    input  logic   wp,
    output logic   lock_q,
    output logic   down_q
);
    // Apply a command to this block; lock-down leaves only through reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b1;
            down_q <= 1'b0;
        end else if (sel) begin
            case (op)
                OP_LOCK:   lock_q <= 1'b1;
                OP_DOWN: begin
                    lock_q <= 1'b1;
                    down_q <= 1'b1;
                end
                OP_UNLOCK: if (!(down_q && !wp)) lock_q <= 1'b0;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/blk_protect_ctrl.sv
// Per-block write protection: decodes addresses, keeps per-block lock state,
// and combines it with the write-protect pin and voltage lockout into prog_ok.
// Assumes the strap is static between resets.
module blk_protect_ctrl
    import bp_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int MAIN_AW  = 15,
    parameter int PARAM_AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_top,
    input  logic              wp,
    input  logic              vpp_low,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              prog_ok,
    input  logic              err_clr,
    output logic              prot_err,
    input  logic [ADDR_W-1:0] qry_addr,
    output logic              qry_lock,
    output logic              qry_down
);
    localparam int NPAR  = 2 ** (MAIN_AW - PARAM_AW);
    localparam int NMAIN = (2 ** (ADDR_W - MAIN_AW)) - 1;
    localparam int NBLK  = NPAR + NMAIN;
    localparam int IDX_W = $clog2(NBLK);
    localparam int NSLOT = 2 ** IDX_W;

    logic [IDX_W-1:0] cmd_idx, req_idx, qry_idx;
    logic [NBLK-1:0]  lock_vec, down_vec;
    logic [NSLOT-1:0] lock_all, down_all;
    bp_op_e           op_e;

    assign op_e = bp_op_e'(cmd_op);

    bp_addr_dec #(.ADDR_W(ADDR_W), .MAIN_AW(MAIN_AW), .PARAM_AW(PARAM_AW), .IDX_W(IDX_W))
        u_dec_cmd (.boot_top(boot_top), .addr(cmd_addr), .idx(cmd_idx));
    bp_addr_dec #(.ADDR_W(ADDR_W), .MAIN_AW(MAIN_AW), .PARAM_AW(PARAM_AW), .IDX_W(IDX_W))
        u_dec_req (.boot_top(boot_top), .addr(req_addr), .idx(req_idx));
    bp_addr_dec #(.ADDR_W(ADDR_W), .MAIN_AW(MAIN_AW), .PARAM_AW(PARAM_AW), .IDX_W(IDX_W))
        u_dec_qry (.boot_top(boot_top), .addr(qry_addr), .idx(qry_idx));

    for (genvar g = 0; g < NBLK; g++) begin : g_cell
        bp_lock_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .sel    (cmd_valid && (cmd_idx == IDX_W'(g))),
            .op     (op_e),
            .wp     (wp),
            .lock_q (lock_vec[g]),
            .down_q (down_vec[g])
        );
    end

    // Pad state to a power of two so every index value selects a bit; spare slots read locked.
    always_comb begin
        lock_all           = '1;
        down_all           = '0;
        lock_all[NBLK-1:0] = lock_vec;
        down_all[NBLK-1:0] = down_vec;
    end

    // Allow a request only for an unlocked, unheld block with programming voltage present.
    assign prog_ok  = req_valid && !vpp_low && !lock_all[req_idx]
                      && !(down_all[req_idx] && !wp);
    assign qry_lock = lock_all[qry_idx];
    assign qry_down = down_all[qry_idx];

    // Sticky error: a refusal sets it, and setting ranks above clearing.
    always_ff @(posedge clk) begin
        if (!rst_n)                      prot_err <= 1'b0;
        else if (req_valid && !prog_ok)  prot_err <= 1'b1;
        else if (err_clr)                prot_err <= 1'b0;
    end
endmodule

// Property checker for blk_protect_ctrl, attached by bind below.
// Assumes the padded state vectors of the top are visible by name.
module bp_checker #(
    parameter int IDX_W = 4,
    parameter int NSLOT = 16,
    parameter int NBLK  = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wp,
    input logic             vpp_low,
    input logic             cmd_valid,
    input logic [1:0]       cmd_op,
    input logic [IDX_W-1:0] cmd_idx,
    input logic [IDX_W-1:0] req_idx,
    input logic             req_valid,
    input logic             prog_ok,
    input logic             err_clr,
    input logic             prot_err,
    input logic [NSLOT-1:0] lock_all,
    input logic [NSLOT-1:0] down_all,
    input logic [NBLK-1:0]  down_vec
);
    assert_vpp_refuse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vpp_low |-> !prog_ok);

    assert_locked_refuse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        prog_ok |-> (!lock_all[req_idx] && !(down_all[req_idx] && !wp)));

    assert_err_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !prog_ok) |=> prot_err);

    assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_err && !err_clr) |=> prot_err);

    assert_down_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(down_vec) & ~down_vec) == '0));

    assert_unlock_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'b10 && down_all[cmd_idx] && !wp && lock_all[cmd_idx])
        |=> lock_all[$past(cmd_idx)]);
endmodule

bind blk_protect_ctrl bp_checker #(.IDX_W(IDX_W), .NSLOT(NSLOT), .NBLK(NBLK)) u_chk (
    .clk(clk), .rst_n(rst_n), .wp(wp), .vpp_low(vpp_low),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_idx(cmd_idx), .req_idx(req_idx),
    .req_valid(req_valid), .prog_ok(prog_ok), .err_clr(err_clr), .prot_err(prot_err),
    .lock_all(lock_all), .down_all(down_all), .down_vec(down_vec)
);

// File: tb/sim_blk_protect_ctrl.sv
module sim_blk_protect_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_top = 1'b0;
    logic        wp = 1'b0;
    logic        vpp_low = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [17:0] cmd_addr = '0;
    logic        req_valid = 1'b0;
    logic [17:0] req_addr = '0;
    logic        prog_ok;
    logic        err_clr = 1'b0;
    logic        prot_err;
    logic [17:0] qry_addr = '0;
    logic        qry_lock;
    logic        qry_down;

    int checks = 0;
    int errors = 0;
    int mlock[15];
    int mdown[15];
    int merr;

    always #(CLK_PERIOD/2) clk = ~clk;

    blk_protect_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .boot_top(boot_top), .wp(wp), .vpp_low(vpp_low),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .req_valid(req_valid), .req_addr(req_addr), .prog_ok(prog_ok),
        .err_clr(err_clr), .prot_err(prot_err),
        .qry_addr(qry_addr), .qry_lock(qry_lock), .qry_down(qry_down)
    );

    function automatic int blk_of(input logic top, input int a);
        if (top) return (a >= 229376) ? 7 + (a - 229376) / 4096 : a / 32768;
        return (a < 32768) ? a / 4096 : 7 + a / 32768;
    endfunction

    function automatic int base_of(input logic top, input int b);
        if (top) return (b < 7) ? b * 32768 : 229376 + (b - 7) * 4096;
        return (b < 8) ? b * 4096 : (b - 7) * 32768;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 15; i++) begin
            mlock[i] = 1;
            mdown[i] = 0;
        end
        merr = 0;
    endtask

    task automatic check(input string tag, input string nm, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, nm, act, exp);
        end
    endtask

    // Compare outputs with the model, then advance one clock and update the model.
    task automatic tick(input string tag);
        int ri, qi, ci, eok;
        #1;
        ri  = blk_of(boot_top, int'(req_addr));
        qi  = blk_of(boot_top, int'(qry_addr));
        eok = (req_valid && !vpp_low && mlock[ri] == 0 && !(mdown[ri] == 1 && !wp)) ? 1 : 0;
        check(tag, "prog_ok", int'(prog_ok), eok);
        check(tag, "qry_lock", int'(qry_lock), mlock[qi]);
        check(tag, "qry_down", int'(qry_down), mdown[qi]);
        check(tag, "prot_err", int'(prot_err), merr);
        @(posedge clk);
        #1;
        if (!rst_n) model_reset();
        else begin
            if (req_valid && eok == 0) merr = 1;
            else if (err_clr) merr = 0;
            if (cmd_valid) begin
                ci = blk_of(boot_top, int'(cmd_addr));
                case (cmd_op)
                    2'b01: mlock[ci] = 1;
                    2'b11: begin mlock[ci] = 1; mdown[ci] = 1; end
                    2'b10: if (!(mdown[ci] == 1 && !wp)) mlock[ci] = 0;
                    default: ;
                endcase
            end
        end
        @(negedge clk);
    endtask

    task automatic do_cmd(input logic [1:0] op, input int a, input string tag);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = 18'(a); qry_addr = 18'(a);
        tick(tag);
        cmd_valid = 1'b0; cmd_op = 2'b00;
        tick(tag);
    endtask

    task automatic do_req(input int a, input string tag);
        req_valid = 1'b1; req_addr = 18'(a); qry_addr = 18'(a);
        tick(tag);
        req_valid = 1'b0;
        tick(tag);
    endtask

    task automatic do_reset(input string tag);
        rst_n = 1'b0;
        tick(tag);
        tick(tag);
        rst_n = 1'b1;
        tick(tag);
    endtask

    initial begin
        model_reset();
        @(negedge clk);
        // R1: reset state, every block locked, nothing held, no error
        do_reset("R1");
        for (int b = 0; b < 15; b++) begin
            qry_addr = 18'(base_of(1'b0, b));
            tick("R1");
        end
        do_req(0, "R6");
        // R2: bottom map boundaries around parameter block 1 and main block 8
        do_cmd(2'b10, 32'h01000, "R2");
        do_req(32'h01FFF, "R2");
        do_req(32'h02000, "R2");
        do_req(32'h00FFF, "R2");
        // R8: clear alone, then refusal together with clear
        err_clr = 1'b1; tick("R8"); err_clr = 1'b0; tick("R8");
        err_clr = 1'b1; req_valid = 1'b1; req_addr = 18'h3F000; tick("R8");
        req_valid = 1'b0; tick("R8"); err_clr = 1'b0; tick("R8");
        do_cmd(2'b10, 32'h08000, "R2");
        do_req(32'h0FFFF, "R2");
        do_req(32'h10000, "R2");
        do_req(32'h07FFF, "R2");
        // R4: sweep, unlock even blocks, then query and request each block
        for (int b = 0; b < 15; b += 2) do_cmd(2'b10, base_of(1'b0, b) + 5, "R4");
        for (int b = 0; b < 15; b++) do_req(base_of(1'b0, b) + 4095, "R4");
        do_cmd(2'b01, 32'h08000, "R4");
        do_cmd(2'b00, 32'h10000, "R4");
        do_req(32'h08000, "R4");
        // R5: lock-down and the write-protect pin
        wp = 1'b0;
        do_cmd(2'b11, 32'h20000, "R5");
        do_cmd(2'b10, 32'h20000, "R5");
        do_req(32'h20000, "R5");
        wp = 1'b1;
        do_cmd(2'b10, 32'h20000, "R5");
        do_req(32'h20000, "R5");
        wp = 1'b0;
        do_req(32'h20000, "R6");
        do_cmd(2'b01, 32'h20000, "R5");
        wp = 1'b1;
        do_cmd(2'b10, 32'h20000, "R5");
        wp = 1'b0;
        // R7: voltage lockout over unlocked blocks
        vpp_low = 1'b1;
        do_req(32'h00000, "R7");
        do_req(32'h30000, "R7");
        vpp_low = 1'b0;
        do_req(32'h00000, "R7");
        // R5: reset clears lock-down
        do_reset("R5");
        qry_addr = 18'h20000; tick("R5");
        // R3: top map
        boot_top = 1'b1;
        do_reset("R3");
        do_cmd(2'b10, 32'h38000, "R3");
        do_req(32'h38FFF, "R3");
        do_req(32'h37FFF, "R3");
        do_req(32'h39000, "R3");
        do_cmd(2'b10, 32'h3F000, "R3");
        do_req(32'h3FFFF, "R3");
        do_cmd(2'b10, 32'h30000, "R3");
        do_req(32'h37FFF, "R3");
        for (int b = 0; b < 15; b++) begin
            qry_addr = 18'(base_of(1'b1, b));
            tick("R9");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule